// File: doc/BRIEF.md
# PS/2 Keyboard Key-Event Receiver

This block listens to a keyboard on the two-wire PS/2 bus and turns the serial byte stream into decoded key events. The open-drain clock and data lines enter from outside the system clock domain. Each one passes through a synchroniser and a glitch filter. The data line is then sampled on every filtered falling edge of the device clock. The receiver checks every 11-bit frame and reports a frame that fails as a one-cycle error pulse.

Prefix bytes are not passed on. A release prefix (F0) and an extended-key prefix (E0) are held as pending flags. The next ordinary scan code is reported as a single event that carries the code, a release flag and an extended flag. The block only receives. A hold input makes it pull the device clock low, which stops the keyboard from sending, and throws away any frame in progress. A frame that stalls half way is discarded after a programmable number of quiet cycles.

Top module: `kbd_scan_decoder`

## Requirements
- R1: A frame is 11 bits, each taken on a filtered falling edge of `kb_clk_i`: a start bit, eight data bits with the least significant bit first, a parity bit and a stop bit. A good frame holding an ordinary code puts that code on `key_code_o` with `key_valid_o` high.
- R2: The nine bits made of the data byte and the parity bit must hold an odd number of ones. Otherwise `frame_err_o` pulses for one cycle and `key_valid_o` stays low.
- R3: A start bit of 1 or a stop bit of 0 raises the same one-cycle `frame_err_o` and no key event.
- R4: A code that follows byte F0 is reported with `key_break_o`=1. A code with no F0 before it is reported with `key_break_o`=0.
- R5: A code that follows byte E0 is reported with `key_ext_o`=1. The sequence E0, F0, code is reported with both flags at 1.
- R6: Bytes E0 and F0 produce no strobe. `key_valid_o` and `frame_err_o` are each high for exactly one cycle per outcome, and never both in the same cycle.
- R7: Each repeat of the same code produces its own key event.
- R8: A bad frame clears any pending E0 or F0 prefix, so the next code is reported with both flags at 0.
- R9: If no falling edge arrives for `TIMEOUT_CYCLES` cycles while a frame is partly received, the bit position returns to the start and the next full frame decodes correctly.
- R10: A low pulse on `kb_clk_i` shorter than `FILT_LEN` system cycles is not counted as a clock edge.
- R11: `kb_clk_pull_o` follows `hold_i` one cycle later. While `hold_i` is high, a frame in progress is discarded without an error.
- R12: After reset, `key_valid_o`, `frame_err_o` and `kb_clk_pull_o` are 0. `key_valid_o` rises `FILT_LEN`+4 system cycles after the final falling edge of a frame is presented at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk_i | input | 1 | Device clock line as seen at the pad |
| kb_dat_i | input | 1 | Device data line as seen at the pad |
| hold_i | input | 1 | Request to inhibit the keyboard |
| kb_clk_pull_o | output | 1 | Enables the open-drain pull-down of the clock line |
| key_valid_o | output | 1 | One-cycle strobe for a decoded key event |
| key_code_o | output | 8 | Final scan code of the event |
| key_break_o | output | 1 | 1 = key released, 0 = key pressed |
| key_ext_o | output | 1 | 1 = extended key |
| frame_err_o | output | 1 | One-cycle pulse for a frame with a bad start, parity or stop bit |

## Verification
A falling clock edge presented at the pin takes two synchroniser cycles and `FILT_LEN` filter cycles to be seen. The frame register adds one more cycle and the event register another. The key strobe is therefore due `FILT_LEN`+4 cycles after the final edge. One scenario counts system edges from that point and expects the strobe on exactly that cycle. The pull-down output is due one cycle after `hold_i` changes and is sampled right after that edge. For all other results, the bench samples between edges and waits half a bit period after each frame before comparing. That wait is well beyond the eight-cycle latency and well short of the next frame.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    localparam int FRAME_BITS = 11;
    localparam int LAST_BIT   = FRAME_BITS - 1;

    localparam logic [7:0] CODE_EXTEND  = 8'hE0;
    localparam logic [7:0] CODE_RELEASE = 8'hF0;

    typedef struct packed {
        logic       done;
        logic       good;
        logic [7:0] data;
    } frame_t;

    typedef struct packed {
        logic       valid;
        logic       err;
        logic       brk;
        logic       ext;
        logic [7:0] code;
    } key_event_t;

    function automatic logic parity_is_odd(input logic [7:0] d, input logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/kbd_line_filter.sv
module kbd_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o,
    output logic fall_o
);
    localparam int CW = $clog2(FILT_LEN) + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   level_q;
    logic                   fall_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[g] <= 1'b1;
                end else if (g == 0) begin
                    sync_q[g] <= pin_i;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            level_q <= 1'b1;
            fall_q  <= 1'b0;
        end else begin
            fall_q <= 1'b0;
            if (synced == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                cnt_q   <= '0;
                level_q <= synced;
                fall_q  <= level_q & ~synced;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_o = level_q;
    assign fall_o  = fall_q;

    // R10: the filtered level only ever moves to the synchronised pin value
    assert_filter_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> (level_q == $past(synced)));

    // R10: an edge pulse accompanies a 1->0 move of the filtered level
    assert_fall_matches_level_R10: assert property (@(posedge clk) disable iff (rst)
        fall_q |-> (!level_q && $past(level_q)));

endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
    import kbd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 25000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   fall_i,
    input  logic   data_i,
    input  logic   abort_i,
    output frame_t frame_o
);
    localparam int IW = $clog2(TIMEOUT_CYCLES) + 1;

    logic [3:0]    bit_q;
    logic [9:0]    shift_q;
    logic [IW-1:0] idle_q;
    frame_t        frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q   <= '0;
            shift_q <= '0;
            idle_q  <= '0;
            frame_q <= '0;
        end else begin
            frame_q.done <= 1'b0;
            if (abort_i) begin
                bit_q  <= '0;
                idle_q <= '0;
            end else if (fall_i) begin
                idle_q <= '0;
                if (bit_q == 4'(LAST_BIT)) begin
                    frame_q.done <= 1'b1;
                    frame_q.good <= !shift_q[0] && data_i &&
                                    parity_is_odd(shift_q[8:1], shift_q[9]);
                    frame_q.data <= shift_q[8:1];
                    bit_q        <= '0;
                end else begin
                    shift_q[bit_q] <= data_i;
                    bit_q          <= bit_q + 1'b1;
                end
            end else if (bit_q != '0) begin
                if (idle_q == IW'(TIMEOUT_CYCLES - 1)) begin
                    bit_q  <= '0;
                    idle_q <= '0;
                end else begin
                    idle_q <= idle_q + 1'b1;
                end
            end
        end
    end

    assign frame_o = frame_q;

    // R1: a completed frame is always the consequence of a falling edge
    assert_done_after_edge_R1: assert property (@(posedge clk) disable iff (rst)
        frame_q.done |-> $past(fall_i));

    // R1: bit position never leaves the frame
    assert_bit_range_R1: assert property (@(posedge clk) disable iff (rst)
        bit_q <= 4'(LAST_BIT));

    // R9: the quiet counter never passes its limit
    assert_idle_bound_R9: assert property (@(posedge clk) disable iff (rst)
        idle_q < IW'(TIMEOUT_CYCLES));

    // R11: an abort returns the frame to its first bit
    assert_abort_clears_R11: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (bit_q == '0));

endmodule

// File: rtl/kbd_seq_decode.sv
module kbd_seq_decode
    import kbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_t     frame_i,
    output key_event_t event_o
);
    logic       ext_pend_q;
    logic       brk_pend_q;
    key_event_t ev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_pend_q <= 1'b0;
            brk_pend_q <= 1'b0;
            ev_q       <= '0;
        end else begin
            ev_q.valid <= 1'b0;
            ev_q.err   <= 1'b0;
            if (frame_i.done) begin
                if (!frame_i.good) begin
                    ev_q.err   <= 1'b1;
                    ext_pend_q <= 1'b0;
                    brk_pend_q <= 1'b0;
                end else if (frame_i.data == CODE_EXTEND) begin
                    ext_pend_q <= 1'b1;
                end else if (frame_i.data == CODE_RELEASE) begin
                    brk_pend_q <= 1'b1;
                end else begin
                    ev_q.valid <= 1'b1;
                    ev_q.code  <= frame_i.data;
                    ev_q.brk   <= brk_pend_q;
                    ev_q.ext   <= ext_pend_q;
                    ext_pend_q <= 1'b0;
                    brk_pend_q <= 1'b0;
                end
            end
        end
    end

    assign event_o = ev_q;

    // R6: a strobe and an error never coincide
    assert_single_outcome_R6: assert property (@(posedge clk) disable iff (rst)
        !(ev_q.valid && ev_q.err));

    // R6: prefix bytes stay silent
    assert_prefix_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_i.done && frame_i.good &&
         (frame_i.data == CODE_EXTEND || frame_i.data == CODE_RELEASE)) |=> !ev_q.valid);

    // R8: a bad frame drops pending prefixes
    assert_err_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_i.done && !frame_i.good) |=> (!ext_pend_q && !brk_pend_q));

    // R4: the release flag of an event comes from a pending prefix
    assert_break_origin_R4: assert property (@(posedge clk) disable iff (rst)
        (ev_q.valid && ev_q.brk) |-> $past(brk_pend_q));

endmodule

// File: rtl/kbd_scan_decoder.sv
module kbd_scan_decoder
    import kbd_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int FILT_LEN       = 4,
    parameter int TIMEOUT_CYCLES = 25000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kb_clk_i,
    input  logic       kb_dat_i,
    input  logic       hold_i,
    output logic       kb_clk_pull_o,
    output logic       key_valid_o,
    output logic [7:0] key_code_o,
    output logic       key_break_o,
    output logic       key_ext_o,
    output logic       frame_err_o
);
    logic       clk_level;
    logic       clk_fall;
    logic       dat_level;
    logic       dat_fall_unused;
    logic       pull_q;
    frame_t     frame;
    key_event_t ev;

    kbd_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_clk_filt (
        .clk(clk), .rst(rst), .pin_i(kb_clk_i),
        .level_o(clk_level), .fall_o(clk_fall)
    );

    kbd_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_dat_filt (
        .clk(clk), .rst(rst), .pin_i(kb_dat_i),
        .level_o(dat_level), .fall_o(dat_fall_unused)
    );

    kbd_frame_rx #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_frame (
        .clk(clk), .rst(rst), .fall_i(clk_fall), .data_i(dat_level),
        .abort_i(hold_i), .frame_o(frame)
    );

    kbd_seq_decode u_seq (
        .clk(clk), .rst(rst), .frame_i(frame), .event_o(ev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pull_q <= 1'b0;
        end else begin
            pull_q <= hold_i;
        end
    end

    assign kb_clk_pull_o = pull_q;
    assign key_valid_o   = ev.valid;
    assign key_code_o    = ev.code;
    assign key_break_o   = ev.brk;
    assign key_ext_o     = ev.ext;
    assign frame_err_o   = ev.err;

    // R11: the pull-down follows the hold request by one cycle
    assert_pull_tracks_R11: assert property (@(posedge clk) disable iff (rst)
        kb_clk_pull_o == $past(hold_i));

    // R6: strobes last a single cycle
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        key_valid_o |=> !key_valid_o);

    // R12: the data line is only observed while the filtered clock is low at an edge
    assert_edge_level_R12: assert property (@(posedge clk) disable iff (rst)
        clk_fall |-> !clk_level);

endmodule

// File: tb/kbd_scan_decoder_tb_top.sv
module kbd_scan_decoder_tb_top;

    localparam int F    = 4;
    localparam int TMO  = 400;
    localparam int HALF = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kclk = 1'b1;
    logic       kdat = 1'b1;
    logic       hold = 1'b0;
    logic       pull;
    logic       valid;
    logic [7:0] code;
    logic       brk;
    logic       ext;
    logic       ferr;

    int checks = 0;
    int fails  = 0;
    int ev_cnt = 0;
    int err_cnt = 0;
    logic [7:0] last_code = '0;
    logic       last_brk  = 1'b0;
    logic       last_ext  = 1'b0;
    bit         finished  = 1'b0;
    int         cycles    = 0;

    always #2 clk = ~clk;

    kbd_scan_decoder #(.SYNC_STAGES(2), .FILT_LEN(F), .TIMEOUT_CYCLES(TMO)) dut_i (
        .clk(clk), .rst(rst), .kb_clk_i(kclk), .kb_dat_i(kdat), .hold_i(hold),
        .kb_clk_pull_o(pull), .key_valid_o(valid), .key_code_o(code),
        .key_break_o(brk), .key_ext_o(ext), .frame_err_o(ferr)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (valid) begin
                ev_cnt    <= ev_cnt + 1;
                last_code <= code;
                last_brk  <= brk;
                last_ext  <= ext;
            end
            if (ferr) err_cnt <= err_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flaw: 0 none, 1 parity, 2 start, 3 stop
    task automatic send_frame(input logic [7:0] b, input int flaw);
        logic [10:0] bits;
        bits[0]    = (flaw == 2);
        bits[8:1]  = b;
        bits[9]    = ~(^b) ^ (flaw == 1);
        bits[10]   = (flaw != 3);
        for (int i = 0; i < 11; i++) begin
            @(negedge clk) kdat = bits[i];
            repeat (HALF) @(negedge clk);
            kclk = 1'b0;
            repeat (HALF) @(negedge clk);
            kclk = 1'b1;
        end
        @(negedge clk) kdat = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic expect_event(input string req, input logic [7:0] c, input logic b,
                                input logic e, input int ev0);
        check(ev_cnt == ev0 + 1, req, ev_cnt - ev0, 1);
        check(last_code == c, req, last_code, c);
        check(last_brk == b, req, last_brk, b);
        check(last_ext == e, req, last_ext, e);
    endtask

    task automatic t_reset_R12;
        check(valid == 1'b0, "R12 reset valid", valid, 0);
        check(ferr == 1'b0, "R12 reset err", ferr, 0);
        check(pull == 1'b0, "R12 reset pull", pull, 0);
    endtask

    task automatic t_latency_R12;
        logic [10:0] bits;
        int seen;
        seen = -1;
        bits = {1'b1, ~(^8'h1C), 8'h1C, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) kdat = bits[i];
            repeat (HALF) @(negedge clk);
            kclk = 1'b0;
            repeat (HALF) @(negedge clk);
            kclk = 1'b1;
        end
        @(negedge clk) kdat = 1'b1;
        repeat (HALF) @(negedge clk);
        kclk = 1'b0;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk);
            #1;
            if (valid && seen < 0) seen = k;
        end
        check(seen == F + 4, "R12 latency", seen, F + 4);
        check(code == 8'h1C || seen > 0, "R12 code", code, 8'h1C);
        repeat (HALF) @(negedge clk);
        kclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic t_make_R1;
        int e0;
        e0 = ev_cnt;
        send_frame(8'h1C, 0);
        expect_event("R1 make 1C", 8'h1C, 1'b0, 1'b0, e0);
        e0 = ev_cnt;
        send_frame(8'h5A, 0);
        expect_event("R1 make 5A", 8'h5A, 1'b0, 1'b0, e0);
    endtask

    task automatic t_break_R4;
        int e0;
        e0 = ev_cnt;
        send_frame(8'hF0, 0);
        check(ev_cnt == e0, "R6 F0 silent", ev_cnt - e0, 0);
        send_frame(8'h33, 0);
        expect_event("R4 break", 8'h33, 1'b1, 1'b0, e0);
    endtask

    task automatic t_ext_R5;
        int e0;
        e0 = ev_cnt;
        send_frame(8'hE0, 0);
        check(ev_cnt == e0, "R6 E0 silent", ev_cnt - e0, 0);
        send_frame(8'h75, 0);
        expect_event("R5 ext make", 8'h75, 1'b0, 1'b1, e0);
        e0 = ev_cnt;
        send_frame(8'hE0, 0);
        send_frame(8'hF0, 0);
        check(ev_cnt == e0, "R6 E0 F0 silent", ev_cnt - e0, 0);
        send_frame(8'h75, 0);
        expect_event("R5 ext break", 8'h75, 1'b1, 1'b1, e0);
    endtask

    task automatic t_repeat_R7;
        int e0;
        e0 = ev_cnt;
        for (int i = 0; i < 3; i++) send_frame(8'h2B, 0);
        check(ev_cnt == e0 + 3, "R7 repeats", ev_cnt - e0, 3);
        check(last_code == 8'h2B, "R7 code", last_code, 8'h2B);
    endtask

    task automatic t_errors_R2_R3;
        int e0, r0;
        e0 = ev_cnt; r0 = err_cnt;
        send_frame(8'h1C, 1);
        check(err_cnt == r0 + 1, "R2 parity err", err_cnt - r0, 1);
        check(ev_cnt == e0, "R2 no event", ev_cnt - e0, 0);
        send_frame(8'h1C, 2);
        check(err_cnt == r0 + 2, "R3 start err", err_cnt - r0, 2);
        send_frame(8'h1C, 3);
        check(err_cnt == r0 + 3, "R3 stop err", err_cnt - r0, 3);
        check(ev_cnt == e0, "R3 no event", ev_cnt - e0, 0);
    endtask

    task automatic t_err_clears_R8;
        int e0;
        e0 = ev_cnt;
        send_frame(8'hE0, 0);
        send_frame(8'hF0, 0);
        send_frame(8'h44, 1);
        send_frame(8'h44, 0);
        expect_event("R8 prefix cleared", 8'h44, 1'b0, 1'b0, e0);
    endtask

    task automatic t_timeout_R9;
        int e0, r0;
        e0 = ev_cnt; r0 = err_cnt;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) kdat = 1'b0;
            repeat (HALF) @(negedge clk);
            kclk = 1'b0;
            repeat (HALF) @(negedge clk);
            kclk = 1'b1;
        end
        kdat = 1'b1;
        repeat (TMO + 200) @(negedge clk);
        send_frame(8'h1B, 0);
        expect_event("R9 after stall", 8'h1B, 1'b0, 1'b0, e0);
        check(err_cnt == r0, "R9 no error", err_cnt - r0, 0);
    endtask

    task automatic t_glitch_R10;
        int e0;
        e0 = ev_cnt;
        @(negedge clk) kclk = 1'b0;
        repeat (2) @(negedge clk);
        kclk = 1'b1;
        repeat (20) @(negedge clk);
        send_frame(8'h2A, 0);
        expect_event("R10 glitch ignored", 8'h2A, 1'b0, 1'b0, e0);
    endtask

    task automatic t_hold_R11;
        int e0, r0;
        e0 = ev_cnt; r0 = err_cnt;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) kdat = 1'b0;
            repeat (HALF) @(negedge clk);
            kclk = 1'b0;
            repeat (HALF) @(negedge clk);
            kclk = 1'b1;
        end
        kdat = 1'b1;
        @(negedge clk) hold = 1'b1;
        @(posedge clk);
        #1;
        check(pull == 1'b1, "R11 pull on", pull, 1);
        repeat (50) @(negedge clk);
        hold = 1'b0;
        @(posedge clk);
        #1;
        check(pull == 1'b0, "R11 pull off", pull, 0);
        repeat (10) @(negedge clk);
        send_frame(8'h15, 0);
        expect_event("R11 frame after hold", 8'h15, 1'b0, 1'b0, e0);
        check(err_cnt == r0, "R11 no error", err_cnt - r0, 0);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset_R12;
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_latency_R12;
        t_make_R1;
        t_break_R4;
        t_ext_R5;
        t_repeat_R7;
        t_errors_R2_R3;
        t_err_clears_R8;
        t_timeout_R9;
        t_glitch_R10;
        t_hold_R11;
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule